// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory whose data phase trails its command phase by exactly two clock edges, for reads and writes alike. Because both directions share that fixed delay, a read may follow a write (or the reverse) on the very next clock with no idle slot on the data bus. The data path is 36 bits wide, organised as four 9-bit lanes that can each be written on their own. The depth is set by an address-width parameter.

Each command either loads a fresh external address or advances an internal 2-bit burst counter. A load yields a burst of up to four words, taken in linear or interleaved order. Three chip enables qualify a load. A clock enable, active low, freezes the whole block. An asynchronous output enable gates the bus drive. The bidirectional bus is modelled as separate input data, output data and drive-enable signals.

Top module: `zbt_sram`

## Requirements
- R1: A read command captured on edge E0 places the word on `dq_out` with `dq_oe` high after edge E0+2, and both hold until the next edge.
- R2: A write command captured on edge E0 takes its data from `dq_in` at edge E0+2. Commands may be issued on every clock, with reads and writes mixed in any order.
- R3: Lane i is bits [9i+8:9i] and is written only if `byte_wr_n[i]` was low in the command cycle. Lanes that are not enabled keep their old contents.
- R4: While `clk_en_n` is high, every synchronous input is ignored and all state holds, including `dq_out`, `dq_oe` and pending transfers. Pending transfers resume when `clk_en_n` returns low.
- R5: With `adv_ld` low and all chip enables active (`ce1_n`=0, `ce2`=1, `ce3_n`=0), a new operation starts at `addr`, with `wr_n`=0 meaning write. With `adv_ld` high, the burst continues as the same operation type, and chip enables and `wr_n` are ignored. In linear order (`burst_mode`=0), step k uses low address bits (a+k) mod 4.
- R6: In interleaved order (`burst_mode`=1, sampled at the load), step k uses low address bits a XOR k.
- R7: A load with any chip enable inactive starts nothing and ends any burst, while operations already issued still complete. An advance with no burst running is a no-operation. `dq_oe` is low two edges after such a cycle.
- R8: `dq_oe` is low in the data phase of a write command.
- R9: `oe_n` high forces `dq_oe` low at once, without waiting for a clock.
- R10: The burst counter wraps inside the aligned four-word block, and bursts longer than four steps repeat that block. The upper address bits never change.
- R11: A read issued in the cycle after a write to the same address returns the newly written lanes.
- R12: A synchronous reset (`rst` high) cancels every pending transfer. `dq_oe` is low and `dq_out` is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| adv_ld | input | 1 | Low loads a new address, high advances the burst |
| wr_n | input | 1 | Low selects write on a load |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| byte_wr_n | input | LANES | Per-lane write enables, active low |
| burst_mode | input | 1 | 0 linear, 1 interleaved burst order |
| addr | input | ADDR_W | Word address for a load |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A corrupted burst counter or latched order bit shows up as wrong data on the second and later words of a burst, two edges after the faulty advance. A pipeline valid bit that is lost or stuck shows up as `dq_oe` misbehaving in the data slot of the affected command: the bus stays dark for a read or is driven during a write. A stall that leaks through shows up at once as `dq_out` or `dq_oe` changing while `clk_en_n` is high, or later as a write stored from data that arrived during the stall. Lane-enable or forwarding faults show up at the next read of the touched address.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  localparam int LANES_DEF  = 4;
  localparam int LANE_W_DEF = 9;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  // Low two address bits for burst step 'step' from starting bits 'start'.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input order_e     ord);
    logic [1:0] r;
    if (ord == ORDER_XOR) r = start ^ step;
    else                  r = start + step;
    return r;
  endfunction

  // All chip enables active.
  function automatic logic chip_selected(input logic c1_n,
                                         input logic c2,
                                         input logic c3_n);
    return ~c1_n & c2 & ~c3_n;
  endfunction

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              adv_ld,
  input  logic              sel_ok,
  input  logic              wr_n,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              issue_valid,
  output logic              issue_wr,
  output logic [ADDR_W-1:0] issue_addr
);

  logic              run_q;
  logic              wr_q;
  order_e            ord_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;
  logic              load_req;

  assign load_req = ~adv_ld;
  assign cnt_nx   = cnt_q + 2'd1;

  always_comb begin
    if (load_req) begin
      issue_valid = sel_ok;
      issue_wr    = ~wr_n;
      issue_addr  = addr;
    end else begin
      issue_valid = run_q;
      issue_wr    = wr_q;
      issue_addr  = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, ord_q)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      wr_q   <= 1'b0;
      ord_q  <= ORDER_LINEAR;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_en) begin
      if (load_req) begin
        run_q  <= sel_ok;
        wr_q   <= ~wr_n;
        ord_q  <= order_e'(mode);
        base_q <= addr;
        cnt_q  <= 2'd0;
      end else if (run_q) begin
        cnt_q  <= cnt_nx;
      end
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
    (step_en && load_req && sel_ok) |=> (run_q && cnt_q == 2'd0)); // R5

  AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (rst)
    (step_en && load_req && !sel_ok) |=> !run_q); // R7

  AST_IDLE_ADV_NOP: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load_req) |-> !issue_valid); // R7

  AST_SAME_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_req && run_q) |=> (base_q == $past(base_q))); // R10

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              in_valid,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_be,
  output logic              out_valid,
  output logic              out_wr,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_be
);

  logic              a_valid, a_wr;
  logic [ADDR_W-1:0] a_addr;
  logic [LANES-1:0]  a_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid   <= 1'b0;
      out_valid <= 1'b0;
      a_wr      <= 1'b0;
      out_wr    <= 1'b0;
      a_addr    <= '0;
      out_addr  <= '0;
      a_be      <= '0;
      out_be    <= '0;
    end else if (step_en) begin
      a_valid   <= in_valid;
      a_wr      <= in_wr;
      a_addr    <= in_addr;
      a_be      <= in_be;
      out_valid <= a_valid;
      out_wr    <= a_wr;
      out_addr  <= a_addr;
      out_be    <= a_be;
    end
  end

  AST_PIPE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(a_valid) && $stable(out_valid) && $stable(out_addr))); // R4

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane_en,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lane_en[g])
        cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    adv_ld,
  input  logic                    wr_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic [LANES-1:0]        byte_wr_n,
  input  logic                    burst_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              step_en;
  logic              sel_ok;
  logic              iss_valid, iss_wr;
  logic [ADDR_W-1:0] iss_addr;
  logic [LANES-1:0]  iss_be;
  logic              b_valid, b_wr;
  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  b_be;
  logic              commit_wr;
  logic              read_fire;
  logic [DATA_W-1:0] rd_word;
  logic              drive_q;
  logic [DATA_W-1:0] dout_q;

  assign step_en = ~clk_en_n;
  assign sel_ok  = chip_selected(ce1_n, ce2, ce3_n);
  assign iss_be  = iss_wr ? ~byte_wr_n : '0;

  zbt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .step_en     (step_en),
    .adv_ld      (adv_ld),
    .sel_ok      (sel_ok),
    .wr_n        (wr_n),
    .mode        (burst_mode),
    .addr        (addr),
    .issue_valid (iss_valid),
    .issue_wr    (iss_wr),
    .issue_addr  (iss_addr)
  );

  zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .in_valid  (iss_valid),
    .in_wr     (iss_wr),
    .in_addr   (iss_addr),
    .in_be     (iss_be),
    .out_valid (b_valid),
    .out_wr    (b_wr),
    .out_addr  (b_addr),
    .out_be    (b_be)
  );

  // Data phase: happens on the edge after the command reaches stage B.
  assign commit_wr = step_en & b_valid & b_wr;
  assign read_fire = step_en & b_valid & ~b_wr;

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk        (clk),
    .wr_en      (commit_wr),
    .wr_addr    (b_addr),
    .wr_lane_en (b_be),
    .wr_data    (dq_in),
    .rd_addr    (b_addr),
    .rd_data    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      dout_q  <= '0;
    end else if (step_en) begin
      drive_q <= read_fire;
      if (read_fire) dout_q <= rd_word;
    end
  end

  assign dq_out = dout_q;
  assign dq_oe  = drive_q & ~oe_n;

  AST_RD_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (step_en && b_valid && !b_wr) |=> drive_q); // R1

  AST_WR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (step_en && b_valid && b_wr) |=> !drive_q); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(dout_q) && $stable(drive_q))); // R4

  AST_EMPTY_SLOT_DARK: assert property (@(posedge clk) disable iff (rst)
    (step_en && !b_valid) |=> !drive_q); // R7

endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  localparam int K_LD_RD = 0;
  localparam int K_LD_WR = 1;
  localparam int K_ADV   = 2;
  localparam int K_DESEL = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          clk_en_n, adv_ld, wr_n, ce1_n, ce2, ce3_n, burst_mode, oe_n;
  logic [NL-1:0] byte_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DW-1:0] mem_m [1 << AW];

  int            sk    [32];
  logic [AW-1:0] sa    [32];
  logic [NL-1:0] sbe   [32];
  logic          smode [32];
  logic [DW-1:0] sdata [32];

  zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .adv_ld(adv_ld), .wr_n(wr_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .byte_wr_n(byte_wr_n),
    .burst_mode(burst_mode), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_desel(input int which);
    adv_ld = 1'b0; wr_n = 1'b1; byte_wr_n = '1;
    ce1_n = (which % 3 == 0); ce2 = (which % 3 != 1); ce3_n = (which % 3 == 2);
    addr = AW'(which * 5);
  endtask

  task automatic drive_entry(input int i);
    case (sk[i])
      K_LD_RD, K_LD_WR: begin
        adv_ld = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        wr_n = (sk[i] == K_LD_RD);
        addr = sa[i]; burst_mode = smode[i]; byte_wr_n = ~sbe[i];
      end
      K_ADV: begin
        // chip enables, wr_n and addr must be ignored on an advance (R5)
        adv_ld = 1'b1; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        wr_n = i[0]; addr = AW'(i * 7); burst_mode = ~smode[i];
        byte_wr_n = ~sbe[i];
      end
      default: drive_desel(i);
    endcase
  endtask

  // Runs a schedule of n commands and checks every data slot.
  task automatic run_sched(input int n, input string tag);
    bit            ev [32];
    bit            ew [32];
    logic [AW-1:0] ea [32];
    bit            act = 0, bwr = 0, bmode = 0;
    logic [AW-1:0] base = '0;
    int            k = 0;
    for (int i = 0; i < n; i++) begin
      ev[i] = 0; ew[i] = 0; ea[i] = '0;
      if (sk[i] == K_LD_RD || sk[i] == K_LD_WR) begin
        act = 1; bwr = (sk[i] == K_LD_WR); bmode = smode[i]; base = sa[i]; k = 0;
        ev[i] = 1; ew[i] = bwr; ea[i] = sa[i];
      end else if (sk[i] == K_ADV) begin
        if (act) begin
          k = (k + 1) % 4;
          ev[i] = 1; ew[i] = bwr;
          ea[i] = base & ~AW'(3);
          if (bmode) ea[i] = ea[i] | (base & AW'(3) ^ AW'(k));
          else       ea[i] = ea[i] | AW'((int'(base & AW'(3)) + k) % 4);
        end
      end else begin
        act = 0;
      end
    end
    for (int i = 0; i < n + 2; i++) begin
      if (i < n) drive_entry(i);
      else       drive_desel(i);
      if (i >= 2 && ev[i-2] && ew[i-2]) dq_in = sdata[i-2];
      else                              dq_in = {DW{i[0]}};
      cyc();
      if (i >= 2) begin
        int j = i - 2;
        if (ev[j] && !ew[j]) begin
          check(dq_oe === 1'b1, tag, "read slot drive", DW'(dq_oe), DW'(1));
          check(dq_out === mem_m[ea[j]], tag, "read data", dq_out, mem_m[ea[j]]);
        end else begin
          check(dq_oe === 1'b0, tag, "non-read slot drive", DW'(dq_oe), DW'(0));
        end
        if (ev[j] && ew[j])
          for (int l = 0; l < NL; l++)
            if (sbe[j][l]) mem_m[ea[j]][l*LW +: LW] = sdata[j][l*LW +: LW];
      end
    end
  endtask

  task automatic set_e(input int i, input int kind, input int a, input logic [NL-1:0] be,
                       input logic m, input logic [DW-1:0] d);
    sk[i] = kind; sa[i] = AW'(a); sbe[i] = be; smode[i] = m; sdata[i] = d;
  endtask

  task automatic t_reset();
    rst = 1'b1; drive_desel(0); cyc(); cyc();
    rst = 1'b0;
    check(dq_oe === 1'b0, "R12", "drive after reset", DW'(dq_oe), DW'(0));
    check(dq_out === '0, "R12", "data after reset", dq_out, '0);
  endtask

  task automatic t_linear();
    // R2 R5 R10: write burst from 9 wraps 9,10,11,8
    set_e(0, K_LD_WR, 9, 4'hF, 0, 36'h1_2345_6789);
    set_e(1, K_ADV,   0, 4'hF, 0, 36'h2_3456_789A);
    set_e(2, K_ADV,   0, 4'hF, 0, 36'h3_4567_89AB);
    set_e(3, K_ADV,   0, 4'hF, 0, 36'h4_5678_9ABC);
    set_e(4, K_LD_RD, 9, 4'hF, 0, '0);
    set_e(5, K_ADV,   0, 4'hF, 0, '0);
    set_e(6, K_ADV,   0, 4'hF, 0, '0);
    set_e(7, K_ADV,   0, 4'hF, 0, '0);
    set_e(8, K_DESEL, 0, 4'h0, 0, '0);
    run_sched(9, "R2/R5");
  endtask

  task automatic t_interleaved();
    // R6: write from 22 goes 22,23,20,21; read from 21 goes 21,20,23,22
    set_e(0, K_LD_WR, 22, 4'hF, 1, 36'hA_0000_0001);
    set_e(1, K_ADV,   0,  4'hF, 1, 36'hB_0000_0002);
    set_e(2, K_ADV,   0,  4'hF, 1, 36'hC_0000_0003);
    set_e(3, K_ADV,   0,  4'hF, 1, 36'hD_0000_0004);
    set_e(4, K_LD_RD, 21, 4'hF, 1, '0);
    set_e(5, K_ADV,   0,  4'hF, 1, '0);
    set_e(6, K_ADV,   0,  4'hF, 1, '0);
    set_e(7, K_ADV,   0,  4'hF, 1, '0);
    run_sched(8, "R6");
  endtask

  task automatic t_mixed();
    // R3 R8 R11: alternating writes and reads, partial lanes 0 and 2
    set_e(0, K_LD_WR, 31, 4'hF, 0, 36'h1_1111_1111);
    set_e(1, K_LD_WR, 30, 4'hF, 0, 36'h2_2222_2222);
    set_e(2, K_LD_RD, 30, 4'hF, 0, '0);
    set_e(3, K_LD_WR, 31, 4'h5, 0, 36'hF_EDCB_A987);
    set_e(4, K_LD_RD, 31, 4'hF, 0, '0);
    set_e(5, K_LD_WR, 30, 4'hA, 0, 36'h5_A5A5_A5A5);
    set_e(6, K_LD_RD, 30, 4'hF, 0, '0);
    set_e(7, K_LD_RD, 31, 4'hF, 0, '0);
    run_sched(8, "R3/R11");
  endtask

  task automatic t_desel_mid();
    // R7: burst ends at deselect, advances after it do nothing
    set_e(0, K_LD_RD, 8, 4'hF, 0, '0);
    set_e(1, K_ADV,   0, 4'hF, 0, '0);
    set_e(2, K_DESEL, 0, 4'h0, 0, '0);
    set_e(3, K_ADV,   0, 4'hF, 0, '0);
    set_e(4, K_ADV,   0, 4'hF, 0, '0);
    set_e(5, K_LD_RD, 9, 4'hF, 0, '0);
    run_sched(6, "R7");
  endtask

  task automatic t_long_wrap();
    // R10: seven steps from 10 stay in block 8..11
    set_e(0, K_LD_RD, 10, 4'hF, 0, '0);
    for (int i = 1; i < 7; i++) set_e(i, K_ADV, 0, 4'hF, 0, '0);
    run_sched(7, "R10");
  endtask

  task automatic t_stall();
    logic [DW-1:0] held;
    drive_entry(0); sk[0] = K_LD_RD;
    adv_ld = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; wr_n = 1; addr = AW'(30); byte_wr_n = '1;
    cyc();
    // R4: junk write commands during the stall must be ignored
    clk_en_n = 1'b1; adv_ld = 0; wr_n = 0; addr = AW'(30); byte_wr_n = '0; dq_in = '1;
    cyc(); cyc(); cyc();
    check(dq_oe === 1'b0, "R4", "drive frozen", DW'(dq_oe), DW'(0));
    clk_en_n = 1'b0; drive_desel(1); cyc();
    drive_desel(2); cyc();
    check(dq_oe === 1'b1, "R4", "read after stall drive", DW'(dq_oe), DW'(1));
    check(dq_out === mem_m[30], "R4", "read after stall data", dq_out, mem_m[30]);
    held = dq_out;
    clk_en_n = 1'b1; adv_ld = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; wr_n = 1; addr = AW'(8);
    cyc(); cyc();
    check(dq_oe === 1'b1, "R4", "drive held in stall", DW'(dq_oe), DW'(1));
    check(dq_out === held, "R4", "data held in stall", dq_out, held);
    clk_en_n = 1'b0; drive_desel(0); cyc();
    check(dq_oe === 1'b0, "R4", "drive after resume", DW'(dq_oe), DW'(0));
    set_e(0, K_LD_RD, 30, 4'hF, 0, '0);
    run_sched(1, "R4");
  endtask

  task automatic t_oe();
    adv_ld = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; wr_n = 1; addr = AW'(31); byte_wr_n = '1;
    cyc();
    drive_desel(1); cyc();
    drive_desel(2); cyc();
    check(dq_oe === 1'b1, "R9", "drive before oe_n", DW'(dq_oe), DW'(1));
    oe_n = 1'b1; #1;
    check(dq_oe === 1'b0, "R9", "oe_n forces off", DW'(dq_oe), DW'(0));
    check(dq_out === mem_m[31], "R9", "data kept", dq_out, mem_m[31]);
    oe_n = 1'b0; #1;
    check(dq_oe === 1'b1, "R9", "oe_n released", DW'(dq_oe), DW'(1));
    drive_desel(0); cyc();
  endtask

  task automatic t_reset_flight();
    adv_ld = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; wr_n = 1; addr = AW'(30); byte_wr_n = '1;
    cyc();
    rst = 1'b1; drive_desel(1); cyc();
    rst = 1'b0; drive_desel(2); cyc();
    check(dq_oe === 1'b0, "R12", "cancelled read slot", DW'(dq_oe), DW'(0));
    cyc();
    check(dq_oe === 1'b0, "R12", "still dark", DW'(dq_oe), DW'(0));
  endtask

  initial begin
    rst = 1'b1; clk_en_n = 1'b0; oe_n = 1'b0; burst_mode = 1'b0; dq_in = '0;
    drive_desel(0);
    @(negedge clk);
    t_reset();
    t_linear();
    t_interleaved();
    t_mixed();
    t_desel_mid();
    t_long_wrap();
    t_stall();
    t_oe();
    t_reset_flight();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule